// File: doc/BRIEF.md
# Call Trap Vectoring Unit

This unit turns one of four software call requests, or a programmed trap request, into a fixed trap sequence. When a request is accepted it selects the trap word address. It latches the caller's condition code and return address, then steps through three strobes: save the current status, save the general registers, and load the new status. In a final modify step it merges the caller's 4-bit R field into the freshly loaded status.

The surrounding processor presents the new status word (condition code, program counter and an auto-increment flag) on the memory inputs during the load strobe cycle. After the modify step the unit raises a one-cycle completion pulse, with the final condition code and program counter on its outputs. Memory timing, the register save itself and execution at the trap location belong to the surrounding logic.

Top module: `calltrap_vec`

## Requirements
- R1: During and after synchronous reset, every strobe and `done` is low, and `vec_addr`, `saved_cc`, `saved_pc`, `new_cc` and `new_pc` are zero.
- R2: A call request with selector k (0 to 3) drives `vec_addr` to CALL_BASE + k (0x48, 0x49, 0x4A, 0x4B by default). The value holds from the save strobe cycle through the `done` cycle.
- R3: A programmed trap request drives `vec_addr` to PROG_VEC (0x47). When a call request and a programmed trap request arrive in the same cycle, the call wins.
- R4: Requests are sampled on the clock edge. `save_stb` is high for the one cycle after acceptance, `greg_stb` for the next cycle, then `load_stb`. One idle modify cycle follows, then `done` for one cycle. At most one of these four outputs is high in any cycle.
- R5: `saved_cc` equals `cur_cc` in the accepting cycle, even if `cur_cc` changes later. For a call, `saved_pc` is `cur_pc` + 1 modulo 2^PCW. For a programmed trap, `saved_pc` is `cur_pc` unchanged.
- R6: For a call, `new_cc` in the `done` cycle is the bitwise OR of the `mem_cc` presented during the `load_stb` cycle and the R field.
- R7: For a call, `new_pc` in the `done` cycle is `mem_pc` + R modulo 2^PCW when `mem_ai` is 1, and `mem_pc` when `mem_ai` is 0. The memory values are the ones presented during the `load_stb` cycle. No carry is signalled.
- R8: For a programmed trap, `new_cc` and `new_pc` equal the loaded `mem_cc` and `mem_pc`, whatever the value of `mem_ai`.
- R9: A request arriving in any cycle other than idle is ignored, including the `done` cycle. It changes neither the vector, the saved values, the results nor the strobe timing, and no new sequence starts after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_req | input | 1 | Call request |
| call_sel | input | KW | Which of the four calls |
| call_r | input | RW | R field of the call |
| prog_req | input | 1 | Programmed trap request |
| cur_cc | input | RW | Current condition code |
| cur_pc | input | PCW | Address of the current instruction |
| mem_cc | input | RW | Loaded condition code, valid in the load cycle |
| mem_pc | input | PCW | Loaded program counter, valid in the load cycle |
| mem_ai | input | 1 | Loaded auto-increment flag, valid in the load cycle |
| vec_addr | output | AW | Trap word address |
| save_stb | output | 1 | Save current status strobe |
| saved_cc | output | RW | Condition code to store |
| saved_pc | output | PCW | Return address to store |
| greg_stb | output | 1 | Save general registers strobe |
| load_stb | output | 1 | Load new status strobe |
| new_cc | output | RW | Final condition code |
| new_pc | output | PCW | Final program counter |
| done | output | 1 | Sequence complete pulse |

## Verification
The assertions assume that the memory inputs are valid in the load strobe cycle and that reset is asserted at time zero. The result checks compare against the memory values sampled two cycles before `done`. The bench drives the memory inputs only in the load cycle, and it scrambles them and `cur_cc` at every other time. This means any sampling in the wrong cycle shows up as a mismatch. Requests during busy cycles are driven on purpose: R9 says they are ignored, so they fall inside the assumed input space.

// File: rtl/calltrap_pkg.sv
package calltrap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SAVE   = 3'd1,
    ST_GREG   = 3'd2,
    ST_LOAD   = 3'd3,
    ST_MODIFY = 3'd4,
    ST_DONE   = 3'd5
  } tstate_e;
endpackage

// File: rtl/calltrap_vecsel.sv
module calltrap_vecsel #(
  parameter int AW        = 17,
  parameter int NUM_CALLS = 4,
  parameter logic [AW-1:0] CALL_BASE = 'h48,
  parameter logic [AW-1:0] PROG_VEC  = 'h47,
  localparam int KW = $clog2(NUM_CALLS)
) (
  input  logic          is_call,
  input  logic [KW-1:0] sel,
  output logic [AW-1:0] vec
);
  always_comb begin
    if (is_call) vec = CALL_BASE + AW'(sel);
    else         vec = PROG_VEC;
  end
endmodule

// File: rtl/calltrap_seq.sv
module calltrap_seq
  import calltrap_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic accept,
  output logic ld_cap,
  output logic mod_en,
  output logic save_stb,
  output logic greg_stb,
  output logic load_stb,
  output logic done
);
  tstate_e state, nxt;

  assign accept = (state == ST_IDLE) && start;
  assign ld_cap = (state == ST_LOAD);
  assign mod_en = (state == ST_MODIFY);

  always_comb begin
    unique case (state)
      ST_IDLE:   nxt = start ? ST_SAVE : ST_IDLE;
      ST_SAVE:   nxt = ST_GREG;
      ST_GREG:   nxt = ST_LOAD;
      ST_LOAD:   nxt = ST_MODIFY;
      ST_MODIFY: nxt = ST_DONE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      save_stb <= 1'b0;
      greg_stb <= 1'b0;
      load_stb <= 1'b0;
      done     <= 1'b0;
    end else begin
      state    <= nxt;
      save_stb <= (nxt == ST_SAVE);
      greg_stb <= (nxt == ST_GREG);
      load_stb <= (nxt == ST_LOAD);
      done     <= (nxt == ST_DONE);
    end
  end
endmodule

// File: rtl/calltrap_merge.sv
module calltrap_merge #(
  parameter int RW  = 4,
  parameter int PCW = 17
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_cap,
  input  logic           mod_en,
  input  logic [RW-1:0]  rfield,
  input  logic [RW-1:0]  mem_cc,
  input  logic [PCW-1:0] mem_pc,
  input  logic           mem_ai,
  output logic [RW-1:0]  new_cc,
  output logic [PCW-1:0] new_pc
);
  logic [RW-1:0]  ld_cc;
  logic [PCW-1:0] ld_pc;
  logic           ld_ai;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_cc  <= '0;
      ld_pc  <= '0;
      ld_ai  <= 1'b0;
      new_cc <= '0;
      new_pc <= '0;
    end else begin
      if (ld_cap) begin
        ld_cc <= mem_cc;
        ld_pc <= mem_pc;
        ld_ai <= mem_ai;
      end
      if (mod_en) begin
        new_cc <= ld_cc | rfield;
        new_pc <= ld_ai ? ld_pc + PCW'(rfield) : ld_pc;
      end
    end
  end
endmodule

// File: rtl/calltrap_vec.sv
module calltrap_vec #(
  parameter int AW        = 17,
  parameter int PCW       = 17,
  parameter int RW        = 4,
  parameter int NUM_CALLS = 4,
  parameter logic [AW-1:0] CALL_BASE = 'h48,
  parameter logic [AW-1:0] PROG_VEC  = 'h47,
  localparam int KW = $clog2(NUM_CALLS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           call_req,
  input  logic [KW-1:0]  call_sel,
  input  logic [RW-1:0]  call_r,
  input  logic           prog_req,
  input  logic [RW-1:0]  cur_cc,
  input  logic [PCW-1:0] cur_pc,
  input  logic [RW-1:0]  mem_cc,
  input  logic [PCW-1:0] mem_pc,
  input  logic           mem_ai,
  output logic [AW-1:0]  vec_addr,
  output logic           save_stb,
  output logic [RW-1:0]  saved_cc,
  output logic [PCW-1:0] saved_pc,
  output logic           greg_stb,
  output logic           load_stb,
  output logic [RW-1:0]  new_cc,
  output logic [PCW-1:0] new_pc,
  output logic           done
);
  logic          accept, ld_cap, mod_en;
  logic [AW-1:0] vec_sel;
  logic [RW-1:0] r_q;

  calltrap_vecsel #(
    .AW(AW), .NUM_CALLS(NUM_CALLS), .CALL_BASE(CALL_BASE), .PROG_VEC(PROG_VEC)
  ) u_vecsel (
    .is_call (call_req),
    .sel     (call_sel),
    .vec     (vec_sel)
  );

  calltrap_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (call_req | prog_req),
    .accept   (accept),
    .ld_cap   (ld_cap),
    .mod_en   (mod_en),
    .save_stb (save_stb),
    .greg_stb (greg_stb),
    .load_stb (load_stb),
    .done     (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_addr <= '0;
      saved_cc <= '0;
      saved_pc <= '0;
      r_q      <= '0;
    end else if (accept) begin
      vec_addr <= vec_sel;
      saved_cc <= cur_cc;
      saved_pc <= call_req ? cur_pc + PCW'(1) : cur_pc;
      r_q      <= call_req ? call_r : '0;
    end
  end

  calltrap_merge #(.RW(RW), .PCW(PCW)) u_merge (
    .clk    (clk),
    .rst    (rst),
    .ld_cap (ld_cap),
    .mod_en (mod_en),
    .rfield (r_q),
    .mem_cc (mem_cc),
    .mem_pc (mem_pc),
    .mem_ai (mem_ai),
    .new_cc (new_cc),
    .new_pc (new_pc)
  );
endmodule

// File: rtl/calltrap_vec_chk.sv
module calltrap_vec_chk #(
  parameter int AW        = 17,
  parameter int PCW       = 17,
  parameter int RW        = 4,
  parameter int NUM_CALLS = 4,
  parameter logic [AW-1:0] CALL_BASE = 'h48,
  parameter logic [AW-1:0] PROG_VEC  = 'h47
) (
  input logic           clk,
  input logic           rst,
  input logic           save_stb,
  input logic           greg_stb,
  input logic           load_stb,
  input logic           done,
  input logic [AW-1:0]  vec_addr,
  input logic [RW-1:0]  mem_cc,
  input logic [PCW-1:0] mem_pc,
  input logic           mem_ai,
  input logic [RW-1:0]  new_cc,
  input logic [PCW-1:0] new_pc
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({save_stb, greg_stb, load_stb, done})); // R4
  AST_GREG_FOLLOWS_SAVE: assert property (@(posedge clk) disable iff (rst)
    save_stb |=> greg_stb); // R4
  AST_LOAD_FOLLOWS_GREG: assert property (@(posedge clk) disable iff (rst)
    greg_stb |=> load_stb); // R4
  AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(load_stb, 2)); // R4
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    save_stb |-> (vec_addr == PROG_VEC ||
                  (vec_addr >= CALL_BASE && vec_addr < CALL_BASE + AW'(NUM_CALLS)))); // R2
  AST_VEC_HELD: assert property (@(posedge clk) disable iff (rst)
    (greg_stb || load_stb || done) |-> $stable(vec_addr)); // R2
  AST_CC_KEEPS_LOADED: assert property (@(posedge clk) disable iff (rst)
    done |-> ((new_cc & $past(mem_cc, 2)) == $past(mem_cc, 2))); // R6
  AST_PC_NO_INC: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(mem_ai, 2)) |-> (new_pc == $past(mem_pc, 2))); // R7
endmodule

bind calltrap_vec calltrap_vec_chk #(
  .AW(AW), .PCW(PCW), .RW(RW), .NUM_CALLS(NUM_CALLS),
  .CALL_BASE(CALL_BASE), .PROG_VEC(PROG_VEC)
) u_chk (
  .clk(clk), .rst(rst), .save_stb(save_stb), .greg_stb(greg_stb),
  .load_stb(load_stb), .done(done), .vec_addr(vec_addr),
  .mem_cc(mem_cc), .mem_pc(mem_pc), .mem_ai(mem_ai),
  .new_cc(new_cc), .new_pc(new_pc)
);

// File: tb/calltrap_vec_test.sv
`timescale 1ns/1ps
module calltrap_vec_test;
  localparam int AW = 17, PCW = 17, RW = 4, KW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic call_req = 1'b0, prog_req = 1'b0, mem_ai = 1'b0;
  logic [KW-1:0]  call_sel = '0;
  logic [RW-1:0]  call_r = '0, cur_cc = '0, mem_cc = '0;
  logic [PCW-1:0] cur_pc = '0, mem_pc = '0;
  logic [AW-1:0]  vec_addr;
  logic save_stb, greg_stb, load_stb, done;
  logic [RW-1:0]  saved_cc, new_cc;
  logic [PCW-1:0] saved_pc, new_pc;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  calltrap_vec uut (
    .clk(clk), .rst(rst), .call_req(call_req), .call_sel(call_sel),
    .call_r(call_r), .prog_req(prog_req), .cur_cc(cur_cc), .cur_pc(cur_pc),
    .mem_cc(mem_cc), .mem_pc(mem_pc), .mem_ai(mem_ai), .vec_addr(vec_addr),
    .save_stb(save_stb), .saved_cc(saved_cc), .saved_pc(saved_pc),
    .greg_stb(greg_stb), .load_stb(load_stb), .new_cc(new_cc),
    .new_pc(new_pc), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] strobes();
    return {save_stb, greg_stb, load_stb, done};
  endfunction

  // kind: 0 call only, 1 programmed only, 2 both at once
  task automatic run(input int kind, input logic [KW-1:0] sel, input logic [RW-1:0] r,
                     input logic [RW-1:0] cc, input logic [PCW-1:0] pc,
                     input logic [RW-1:0] mcc, input logic [PCW-1:0] mpc,
                     input logic mai, input bit poke);
    logic [AW-1:0]  e_vec;
    logic [PCW-1:0] e_spc, e_pc;
    logic [RW-1:0]  e_r, e_cc;
    bit is_call;
    is_call = (kind != 1);
    e_vec = is_call ? AW'(17'h48 + sel) : AW'(17'h47);
    e_spc = is_call ? pc + PCW'(1) : pc;
    e_r   = is_call ? r : '0;
    e_cc  = mcc | e_r;
    e_pc  = mai ? mpc + PCW'(e_r) : mpc;

    @(negedge clk);
    call_req = is_call; prog_req = (kind != 0);
    call_sel = sel; call_r = r; cur_cc = cc; cur_pc = pc;
    @(negedge clk);
    chk(strobes() == 4'b1000, "R4 save strobe", 32'(strobes()), 32'h8);
    chk(vec_addr == e_vec, (kind == 0) ? "R2 call vector" : "R3 prog vector",
        32'(vec_addr), 32'(e_vec));
    chk(saved_cc == cc, "R5 saved cc", 32'(saved_cc), 32'(cc));
    chk(saved_pc == e_spc, "R5 saved pc", 32'(saved_pc), 32'(e_spc));
    call_req = poke; prog_req = poke; call_sel = ~sel; call_r = ~r;
    cur_cc = ~cc; cur_pc = ~pc;
    @(negedge clk);
    chk(strobes() == 4'b0100, "R4 greg strobe", 32'(strobes()), 32'h4);
    @(negedge clk);
    chk(strobes() == 4'b0010, "R4 load strobe", 32'(strobes()), 32'h2);
    mem_cc = mcc; mem_pc = mpc; mem_ai = mai;
    @(negedge clk);
    chk(strobes() == 4'b0000, "R4 modify gap", 32'(strobes()), 32'h0);
    mem_cc = ~mcc; mem_pc = ~mpc; mem_ai = ~mai;
    @(negedge clk);
    chk(strobes() == 4'b0001, "R4 done pulse", 32'(strobes()), 32'h1);
    chk(new_cc == e_cc, is_call ? "R6 merged cc" : "R8 prog cc",
        32'(new_cc), 32'(e_cc));
    chk(new_pc == e_pc, is_call ? "R7 merged pc" : "R8 prog pc",
        32'(new_pc), 32'(e_pc));
    chk(vec_addr == e_vec && saved_cc == cc && saved_pc == e_spc,
        poke ? "R9 busy request ignored" : "R2 vector held",
        32'(vec_addr), 32'(e_vec));
    @(negedge clk);
    call_req = 1'b0; prog_req = 1'b0;
    chk(strobes() == 4'b0000, poke ? "R9 no restart after done" : "R4 back to idle",
        32'(strobes()), 32'h0);
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(strobes() == 4'b0000 && vec_addr == '0 && saved_cc == '0 && saved_pc == '0
        && new_cc == '0 && new_pc == '0, "R1 reset state", 32'(strobes()), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(strobes() == 4'b0000 && new_pc == '0, "R1 idle after reset",
        32'(strobes()), 32'h0);
    for (int k = 0; k < 4; k++)
      for (int r = 0; r < 16; r++)
        for (int a = 0; a < 2; a++)
          run(0, KW'(k), RW'(r), RW'(r * 3 + k), (k == 3) ? 17'h1FFFF : PCW'(k * 4099 + r),
              RW'(k * 5 + a), 17'h1FFF8 + PCW'(r ^ k), a[0], (r % 2) == 1);
    for (int p = 0; p < 4; p++)
      run(1, KW'(p), 4'hF, RW'(p + 9), PCW'(p * 777), RW'(p * 2),
          17'h1FFFE, 1'b1, p[0]);
    run(2, 2'd2, 4'h5, 4'h3, 17'h00100, 4'h8, 17'h00200, 1'b1, 1'b0); // R3 call wins
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule